// File: doc/BRIEF.md
# Byte ALU with Packed-BCD Arithmetic and Flag Update

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each accepted request carries an operation code, two operand bytes and the incoming carry and decimal-mode flags. One clock later the block returns the result byte, new values for the negative (N), overflow (V), zero (Z) and carry (C) flags, and a write mask. The mask tells the status register which of the four flags the operation updates. The register file, memory, instruction sequencing and the status register itself are outside this block.

Add and subtract work in one of two modes. In binary mode they use plain 8-bit arithmetic. In decimal mode each operand is treated as two packed BCD digits, so the values run from 00 to 99 and the carry point is 100. The decimal-mode flag has no effect on any other operation. The flag rules are this core's own. Binary add raises V together with C on unsigned overflow. Binary subtract raises V on a negative difference. Decimal subtract reports a negative difference on N. Compare sets N only when the first operand is lower.

The request input has no stall. One operation can be accepted on every clock. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block accepts requests from the third rising edge after `rst_n` goes high.

Top module: `byte_alu`

## Requirements
- R1: OR (code 0), AND (1) and XOR (2) combine A with B. They set N to bit 7 of the result and Z when the result is zero. The mask is 4'b1010 (bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C; every masked-off flag output reads 0).
- R2: Binary add (code 3, decimal input 0) returns the low byte of A+B+carry. It sets both C and V when the sum exceeds 255, sets Z when the low byte is zero and sets N from bit 7 of the low byte. The mask is 4'b1111.
- R3: Decimal add (code 3, decimal input 1) turns each operand into the value 10*high digit + low digit and adds the carry. If the sum exceeds 99, it sets C and V and subtracts 100. The remaining value comes back as two packed BCD digits. Z is set when that value is zero and N is taken from its bit 7. The mask is 4'b1111. Operands with a digit above 9 give unspecified results.
- R4: Binary subtract (code 4, decimal input 0) computes d = A - B - (1 - carry) as a signed number. It sets Z and C when d is 0, C alone when d is positive and V when d is negative. N is bit 7 of the low byte of d, and the result is that low byte. An all-zero byte from d = -256 does not set Z. The mask is 4'b1111.
- R5: Decimal subtract (code 4, decimal input 1) forms the same difference from the two BCD values. It sets Z and C when the difference is 0 and C alone when it is positive. When the difference is negative it sets N and adds 100 before converting back to BCD. V always reads 0. The mask is 4'b1111.
- R6: Compare (code 5) returns A unchanged. It sets C and Z when A equals B, C alone when A is greater and N alone when A is lower. The mask is 4'b1011.
- R7: Bit test (code 12) returns A unchanged. It sets Z when A AND B is zero and copies B bit 7 into N and B bit 6 into V. The mask is 4'b1110.
- R8: Shift left (code 8) moves A bit 7 into C and fills bit 0 with 0. Logical shift right (code 9) moves A bit 0 into C and fills bit 7 with 0, so N is always 0. Both set N and Z from the result, and the mask is 4'b1011.
- R9: Rotate left (code 10) fills bit 0 with the incoming carry. Rotate right (code 11) fills bit 7 with the incoming carry. In both, the bit shifted out of A becomes C, N and Z follow the result, and the mask is 4'b1011.
- R10: Increment (code 6) and decrement (code 7) add or subtract 1 from A modulo 256. They update N and Z only, so the mask is 4'b1010 and C reads 0.
- R11: Codes 13, 14 and 15 are reserved. They return A with mask 4'b0000 and all flag outputs 0.
- R12: A request accepted at one rising edge appears on the outputs after that edge, with `out_valid` high for exactly that cycle. With `in_valid` low the result, mask and flags hold their values. After reset all outputs are 0.
- R13: The decimal-mode input changes no operation other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| decimal_in | input | 1 | Current decimal-mode flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 8 | Result byte |
| flag_wr_mask | output | 4 | Flag write enables {N,V,Z,C} |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |

## Verification
The only state in the block is its output register and its reset synchroniser. A wrong internal decision therefore shows up on the ports in the first cycle after the request that caused it. Such a decision could be picking the wrong unit, wrapping a decimal value wrongly or taking a flag from the wrong step of a calculation. The bench compares every returned result against a reference model in that same cycle. It covers the edges where the flag rules change: sums of exactly 256 and 100, a binary difference of -256, a decimal difference of -100 and equal compares. Missed clock enables show up as a changed output during idle cycles.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int DW   = 8;          // operand and result width
  localparam int SW   = DW + 2;     // signed/extended working width
  localparam int FW   = 4;          // number of reported flags
  localparam int DEC_BASE = 100;    // packed-BCD wrap value

  // mask / flag positions
  localparam int FI_N = 3;
  localparam int FI_V = 2;
  localparam int FI_Z = 1;
  localparam int FI_C = 0;

  typedef enum logic [3:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_CMP = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_ASL = 4'd8,
    OP_LSR = 4'd9,
    OP_ROL = 4'd10,
    OP_ROR = 4'd11,
    OP_BIT = 4'd12,
    OP_RS0 = 4'd13,
    OP_RS1 = 4'd14,
    OP_RS2 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic [FW-1:0] wr;
    logic          n;
    logic          v;
    logic          z;
    logic          c;
  } alu_out_t;

  // two packed digits -> binary value
  function automatic logic [DW-1:0] dig2bin(input logic [DW-1:0] x);
    return DW'(x[DW-1:DW/2] * 4'd10) + DW'(x[DW/2-1:0]);
  endfunction

  // binary value -> two packed digits
  function automatic logic [DW-1:0] bin2dig(input logic [SW-1:0] v);
    logic [SW-1:0] tens;
    logic [SW-1:0] ones;
    tens = v / SW'(10);
    ones = v % SW'(10);
    return {tens[DW/2-1:0], ones[DW/2-1:0]};
  endfunction

endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          dec,
  output alu_out_t      o
);

  localparam logic [SW-1:0] WRAP   = SW'(DEC_BASE);
  localparam logic [SW-1:0] BINMAX = SW'((1 << DW) - 1);
  localparam logic [SW-1:0] DECMAX = SW'(DEC_BASE - 1);

  logic [SW-1:0] cin_x, brw_x;
  logic [SW-1:0] bsum, dsum, bdif, ddif, adj;
  logic          neg;

  assign cin_x = {{(SW-1){1'b0}}, cin};
  assign brw_x = {{(SW-1){1'b0}}, ~cin};
  assign bsum  = {2'b00, a} + {2'b00, b} + cin_x;
  assign dsum  = {2'b00, dig2bin(a)} + {2'b00, dig2bin(b)} + cin_x;
  assign bdif  = {2'b00, a} - {2'b00, b} - brw_x;
  assign ddif  = {2'b00, dig2bin(a)} - {2'b00, dig2bin(b)} - brw_x;

  always_comb begin
    o     = '0;
    o.res = a;
    adj   = dsum;
    neg   = 1'b0;
    case (op)
      OP_ADD: begin
        o.wr = 4'b1111;
        if (dec) begin
          if (dsum > DECMAX) begin
            adj = dsum - WRAP;
            o.c = 1'b1;
            o.v = 1'b1;
          end
          o.res = bin2dig(adj);
          o.n   = adj[DW-1];
          o.z   = (adj == '0);
        end else begin
          o.c   = (bsum > BINMAX);
          o.v   = (bsum > BINMAX);
          o.res = bsum[DW-1:0];
          o.n   = bsum[DW-1];
          o.z   = (bsum[DW-1:0] == '0);
        end
      end
      OP_SUB: begin
        o.wr = 4'b1111;
        if (dec) begin
          neg   = ddif[SW-1];
          adj   = neg ? ddif + WRAP : ddif;
          o.res = bin2dig(adj);
          o.n   = neg;
          o.c   = ~neg;
          o.z   = (ddif == '0);
        end else begin
          neg   = bdif[SW-1];
          o.res = bdif[DW-1:0];
          o.n   = bdif[DW-1];
          o.v   = neg;
          o.c   = ~neg;
          o.z   = (bdif == '0);
        end
      end
      OP_CMP: begin
        o.wr = 4'b1011;
        if (a == b) begin
          o.c = 1'b1;
          o.z = 1'b1;
        end else if (a > b) begin
          o.c = 1'b1;
        end else begin
          o.n = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output alu_out_t      o
);

  logic [DW-1:0] r;
  logic          co;

  always_comb begin
    o  = '0;
    r  = a;
    co = 1'b0;
    case (op)
      OP_OR:  r = a | b;
      OP_AND: r = a & b;
      OP_XOR: r = a ^ b;
      OP_INC: r = a + DW'(1);
      OP_DEC: r = a - DW'(1);
      OP_ASL: begin r = {a[DW-2:0], 1'b0}; co = a[DW-1]; end
      OP_LSR: begin r = {1'b0, a[DW-1:1]}; co = a[0];    end
      OP_ROL: begin r = {a[DW-2:0], cin};  co = a[DW-1]; end
      OP_ROR: begin r = {cin, a[DW-1:1]};  co = a[0];    end
      default: r = a;
    endcase

    o.res = r;
    case (op)
      OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC: begin
        o.wr = 4'b1010;
        o.n  = r[DW-1];
        o.z  = (r == '0);
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        o.wr = 4'b1011;
        o.n  = r[DW-1];
        o.z  = (r == '0);
        o.c  = co;
      end
      OP_BIT: begin
        o.wr = 4'b1110;
        o.z  = ((a & b) == '0);
        o.n  = b[DW-1];
        o.v  = b[DW-2];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          carry_in,
  input  logic          decimal_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [FW-1:0] flag_wr_mask,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  // unit selection
  alu_op_e  op;
  alu_out_t ar_o, lg_o, sel_o;
  logic     is_arith, is_logic;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  assign is_logic = (op_code <= 4'(OP_BIT)) && !is_arith;

  byte_alu_arith u_arith (
    .op (op), .a (opnd_a), .b (opnd_b), .cin (carry_in), .dec (decimal_in),
    .o  (ar_o)
  );

  byte_alu_logic u_logic (
    .op (op), .a (opnd_a), .b (opnd_b), .cin (carry_in),
    .o  (lg_o)
  );

  // next-state
  logic          vld_d;
  logic [DW-1:0] res_d;
  logic [FW-1:0] msk_d, flg_d;

  always_comb begin
    sel_o = '0;
    sel_o.res = opnd_a;
    if (is_arith)      sel_o = ar_o;
    else if (is_logic) sel_o = lg_o;
    vld_d = in_valid;
    res_d = sel_o.res;
    msk_d = sel_o.wr;
    flg_d = {sel_o.n, sel_o.v, sel_o.z, sel_o.c} & sel_o.wr;
  end

  // registers
  logic [FW-1:0] flg_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_wr_mask <= '0;
      flg_q        <= '0;
    end else begin
      out_valid <= vld_d;
      if (in_valid) begin
        result       <= res_d;
        flag_wr_mask <= msk_d;
        flg_q        <= flg_d;
      end
    end
  end

  assign flag_n = flg_q[FI_N];
  assign flag_v = flg_q[FI_V];
  assign flag_z = flg_q[FI_Z];
  assign flag_c = flg_q[FI_C];

  // assertions
  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_wr_mask));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  a_r10_incdec_nz_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && (op_code == 4'(OP_INC) || op_code == 4'(OP_DEC))
    |=> flag_wr_mask == 4'b1010 && !flag_c && !flag_v);

  a_r8_lsr_clears_n: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && op_code == 4'(OP_LSR) |=> !flag_n && flag_c == $past(opnd_a[0]));

  a_r6_cmp_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && op_code == 4'(OP_CMP)
    |=> !(flag_n && flag_c) && (!flag_z || flag_c) && result == $past(opnd_a));

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && op_code > 4'(OP_BIT)
    |=> flag_wr_mask == '0 && !flag_n && !flag_v && !flag_z && !flag_c
        && result == $past(opnd_a));

  a_r3_digits_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && op_code == 4'(OP_ADD) && decimal_in
    && opnd_a[7:4] <= 4'd9 && opnd_a[3:0] <= 4'd9
    && opnd_b[7:4] <= 4'd9 && opnd_b[3:0] <= 4'd9
    |=> result[7:4] <= 4'd9 && result[3:0] <= 4'd9 && flag_c == flag_v);

  a_r5_dec_sub_no_v: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && op_code == 4'(OP_SUB) && decimal_in |=> !flag_v && (flag_n != flag_c));

endmodule

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] op_code;
  logic [7:0] opnd_a, opnd_b;
  logic       carry_in, decimal_in;
  logic       out_valid;
  logic [7:0] result;
  logic [3:0] flag_wr_mask;
  logic       flag_n, flag_v, flag_z, flag_c;

  always #2 clk = ~clk;   // 250 MHz

  byte_alu dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_code (op_code),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .carry_in (carry_in),
    .decimal_in (decimal_in), .out_valid (out_valid), .result (result),
    .flag_wr_mask (flag_wr_mask), .flag_n (flag_n), .flag_v (flag_v),
    .flag_z (flag_z), .flag_c (flag_c)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit    pend = 0;
  int    exp_r, exp_m, exp_f;   // exp_f packed {N,V,Z,C}
  string exp_tag;

  function automatic int d2b(int x);
    return ((x >> 4) & 15) * 10 + (x & 15);
  endfunction

  function automatic int b2d(int v);
    return (((v / 10) % 16) << 4) | (v % 10);
  endfunction

  function automatic string tag_of(int op, int dec);
    if (dec != 0 && op != 3 && op != 4) return "R13";
    case (op)
      0, 1, 2:  return "R1";
      3:        return dec ? "R3" : "R2";
      4:        return dec ? "R5" : "R4";
      5:        return "R6";
      6, 7:     return "R10";
      8, 9:     return "R8";
      10, 11:   return "R9";
      12:       return "R7";
      default:  return "R11";
    endcase
  endfunction

  task automatic model(input int op, a, b, c, dec,
                       output int r, output int m, output int f);
    int n, v, z, cy, s, neg;
    n = 0; v = 0; z = 0; cy = 0; r = a; m = 0;
    case (op)
      0, 1, 2, 6, 7: begin
        if (op == 0) r = a | b;
        if (op == 1) r = a & b;
        if (op == 2) r = a ^ b;
        if (op == 6) r = (a + 1) % 256;
        if (op == 7) r = (a + 255) % 256;
        m = 'b1010; n = r / 128; z = (r == 0);
      end
      3: begin
        m = 'b1111;
        if (dec) begin
          s = d2b(a) + d2b(b) + c;
          if (s > 99) begin cy = 1; v = 1; s = s - 100; end
          r = b2d(s); z = (s == 0); n = (s / 128) % 2;
        end else begin
          s = a + b + c;
          if (s > 255) begin cy = 1; v = 1; end
          r = s % 256; z = (r == 0); n = r / 128;
        end
      end
      4: begin
        m = 'b1111;
        if (dec) begin
          s = d2b(a) - d2b(b) - (1 - c);
          z = (s == 0); neg = (s < 0); cy = !neg; n = neg;
          if (neg) s = s + 100;
          r = b2d(s);
        end else begin
          s = a - b - (1 - c);
          z = (s == 0); neg = (s < 0); cy = !neg; v = neg;
          r = (s + 512) % 256; n = r / 128;
        end
      end
      5: begin
        m = 'b1011;
        if (a == b) begin cy = 1; z = 1; end
        else if (a > b) cy = 1;
        else n = 1;
      end
      8, 9, 10, 11: begin
        m = 'b1011;
        if (op == 8)  begin r = (a * 2) % 256;       cy = a / 128; end
        if (op == 9)  begin r = a / 2;               cy = a % 2;   end
        if (op == 10) begin r = (a * 2) % 256 + c;   cy = a / 128; end
        if (op == 11) begin r = a / 2 + 128 * c;     cy = a % 2;   end
        n = r / 128; z = (r == 0);
      end
      12: begin
        m = 'b1110; z = ((a & b) == 0); n = (b >> 7) & 1; v = (b >> 6) & 1;
      end
      default: ;
    endcase
    f = n * 8 + v * 4 + z * 2 + cy;
  endtask

  task automatic check_pending();
    int got_f;
    got_f = {28'd0, flag_n, flag_v, flag_z, flag_c};
    if (pend) begin
      checks++;
      if (!out_valid || result != exp_r[7:0] || flag_wr_mask != exp_m[3:0]
          || got_f != exp_f) begin
        fails++;
        $display("FAIL %s: got v=%0b r=%02h m=%04b f=%04b, expected v=1 r=%02h m=%04b f=%04b",
                 exp_tag, out_valid, result, flag_wr_mask, got_f[3:0],
                 exp_r[7:0], exp_m[3:0], exp_f[3:0]);
      end
    end
    pend = 0;
  endtask

  // drive at the falling edge after checking the previous request
  task automatic issue(input int op, a, b, c, dec);
    @(negedge clk);
    check_pending();
    in_valid   = 1'b1;
    op_code    = op[3:0];
    opnd_a     = a[7:0];
    opnd_b     = b[7:0];
    carry_in   = c[0];
    decimal_in = dec[0];
    model(op, a, b, c, dec, exp_r, exp_m, exp_f);
    exp_tag = tag_of(op, dec);
    pend = 1;
  endtask

  task automatic idle_check();
    logic [7:0] r0;
    logic [3:0] m0;
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;
    opnd_a   = 8'h5A;
    op_code  = 4'd2;
    r0 = result; m0 = flag_wr_mask;
    @(negedge clk);
    checks++;
    if (out_valid || result != r0 || flag_wr_mask != m0) begin
      fails++;
      $display("FAIL R12: idle got v=%0b r=%02h m=%04b, expected v=0 r=%02h m=%04b",
               out_valid, result, flag_wr_mask, r0, m0);
    end
  endtask

  function automatic int rbcd();
    return (($urandom % 10) << 4) | ($urandom % 10);
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
    carry_in = 1'b0; decimal_in = 1'b0;
    repeat (3) @(negedge clk);
    checks++;  // R12 reset state
    if (out_valid || result != 8'h00 || flag_wr_mask != 4'h0
        || flag_n || flag_v || flag_z || flag_c) begin
      fails++;
      $display("FAIL R12: reset state got v=%0b r=%02h m=%04b, expected all zero",
               out_valid, result, flag_wr_mask);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 logic ops
    issue(0, 8'h00, 8'h00, 0, 0);
    issue(2, 8'hAA, 8'h55, 1, 0);
    issue(1, 8'hF0, 8'h3C, 0, 0);
    // R2 binary add edges
    issue(3, 8'hFF, 8'h01, 0, 0);
    issue(3, 8'h50, 8'h50, 0, 0);
    issue(3, 8'h7F, 8'h00, 1, 0);
    // R3 decimal add
    issue(3, 8'h99, 8'h01, 0, 1);
    issue(3, 8'h45, 8'h38, 1, 1);
    issue(3, 8'h50, 8'h50, 0, 1);
    // R4 binary subtract, incl. -256
    issue(4, 8'h05, 8'h05, 1, 0);
    issue(4, 8'h05, 8'h06, 1, 0);
    issue(4, 8'h00, 8'hFF, 0, 0);
    issue(4, 8'h10, 8'h01, 0, 0);
    // R5 decimal subtract, incl. -100
    issue(4, 8'h00, 8'h99, 0, 1);
    issue(4, 8'h42, 8'h13, 1, 1);
    issue(4, 8'h10, 8'h20, 1, 1);
    // R6 compare
    issue(5, 8'h33, 8'h33, 0, 0);
    issue(5, 8'hF0, 8'h10, 0, 0);
    issue(5, 8'h10, 8'hF0, 1, 0);
    // R7 bit test
    issue(12, 8'h0F, 8'hC0, 0, 0);
    issue(12, 8'hFF, 8'h41, 1, 0);
    // R8 shifts
    issue(8, 8'h81, 8'h00, 0, 0);
    issue(9, 8'h01, 8'h00, 0, 0);
    issue(9, 8'hFF, 8'h00, 1, 0);
    // R9 rotates
    issue(10, 8'h80, 8'h00, 1, 0);
    issue(11, 8'h01, 8'h00, 1, 0);
    issue(11, 8'h02, 8'h00, 0, 0);
    // R10 inc/dec wrap
    issue(6, 8'hFF, 8'h00, 1, 0);
    issue(7, 8'h00, 8'h00, 1, 0);
    // R11 reserved
    issue(13, 8'h12, 8'h34, 1, 0);
    issue(14, 8'h80, 8'hFF, 0, 1);
    issue(15, 8'h00, 8'h00, 1, 1);
    // R13 decimal flag ignored elsewhere
    issue(0, 8'h09, 8'h90, 0, 1);
    issue(8, 8'h99, 8'h00, 1, 1);
    issue(5, 8'h09, 8'h10, 0, 1);
    issue(6, 8'h09, 8'h00, 0, 1);
    // R12 hold while idle
    idle_check();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op, dec;
      op  = $urandom % 16;
      dec = $urandom % 2;
      if ((op == 3 || op == 4) && dec)
        issue(op, rbcd(), rbcd(), $urandom % 2, 1);
      else
        issue(op, $urandom % 256, $urandom % 256, $urandom % 2, dec);
      if (i % 37 == 0) idle_check();
    end
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule